// File: doc/BRIEF.md
# Branch Target Address Generator

This unit produces the next program counter for the control-transfer forms of a small 8-bit accumulator processor. Each issue cycle it receives the address of the instruction being retired, that instruction's length in bytes, a code for the branch kind, up to two operand bytes, the accumulator, the 16-bit data pointer and a single taken flag. It holds the resulting address in a register. The condition logic that sets the taken flag (carry tests, bit tests, compare, decrement-and-test) belongs to the neighbouring execution stage.

Every PC-relative form is computed from the address that follows the branch, which is the instruction address plus the length. The relative kind adds a sign-extended 8-bit offset to that base, and only when the condition holds. The page-absolute kind keeps the top five bits of that base and fills in the low eleven bits from the operand. This splits the 64 KB code space into 32 pages of 2 KB. The long kind loads a full 16-bit operand. The indexed kind adds the accumulator to the data pointer. All sums wrap at 2^16 and raise no flag.

Top module: `brtgt_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `next_pc_o` reads 16'h0000.
- R2: At a rising clock edge where `issue_i` is low, `next_pc_o` keeps its value. It does so whatever the other inputs are.
- R3: Kind code 0 (sequential), and the unused codes 5, 6 and 7, produce `insn_addr_i + insn_len_i` modulo 2^16.
- R4: Kind code 1 (relative) with `taken_i` high produces (`insn_addr_i + insn_len_i` + `opnd_lo_i` read as a signed 8-bit value) modulo 2^16. This covers the offset range -128 to +127.
- R5: Kind code 1 with `taken_i` low produces `insn_addr_i + insn_len_i` modulo 2^16.
- R6: Kind code 2 (page absolute) produces bits [15:11] from `insn_addr_i + insn_len_i`, bits [10:8] from `opnd_hi_i[2:0]` and bits [7:0] from `opnd_lo_i`. `opnd_hi_i[7:3]` is ignored. The page is taken from the following instruction, even where the branch itself straddles a page edge.
- R7: Kind code 3 (long) produces `{opnd_hi_i, opnd_lo_i}` and ignores `insn_addr_i` and `insn_len_i`.
- R8: Kind code 4 (indexed) produces `dptr_i` plus the zero-extended `acc_i`, modulo 2^16.
- R9: `taken_i` has no effect for kind codes 0, 2, 3 and 4.
- R10: The result selected at a rising edge where `issue_i` is high appears on `next_pc_o` right after that edge, with one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_i | input | 1 | Load the computed target into the output register |
| insn_addr_i | input | 16 | Address of the branch instruction |
| insn_len_i | input | 2 | Instruction length in bytes |
| kind_i | input | 3 | Branch kind: 0 seq, 1 relative, 2 page absolute, 3 long, 4 indexed |
| opnd_lo_i | input | 8 | Low operand byte (offset, or target low byte) |
| opnd_hi_i | input | 8 | High operand byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| taken_i | input | 1 | Condition result for relative branches |
| next_pc_o | output | 16 | Registered next program counter |

## Verification
The hardest cases to reach are the ones where adding the length moves the base into another page or past the top of memory. These are a page-absolute branch whose opcode sits on the last byte of a 2 KB page, and a relative branch near 16'hFFFF. Random stimulus would rarely land there. The directed tasks therefore place the instruction address at 16'h07FF, 16'hFFFF and 16'hFFFE on purpose. They pair those addresses with the extreme offsets 8'h7F and 8'h80, and with operand high bytes that carry ones in the ignored bits.

// File: rtl/brtgt_pkg.sv
package brtgt_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 11;
  localparam int LEN_W  = 2;

  typedef enum logic [2:0] {
    BK_SEQ  = 3'd0,
    BK_REL  = 3'd1,
    BK_PAGE = 3'd2,
    BK_LONG = 3'd3,
    BK_IDX  = 3'd4
  } br_kind_e;
endpackage

// File: rtl/brtgt_seq_step.sv
module brtgt_seq_step #(
  parameter int AW = 16,
  parameter int LW = 2
) (
  input  logic [AW-1:0] addr_i,
  input  logic [LW-1:0] len_i,
  output logic [AW-1:0] seq_o
);
  function automatic logic [AW-1:0] f_step(input logic [AW-1:0] a, input logic [LW-1:0] n);
    return a + AW'(n);
  endfunction

  assign seq_o = f_step(addr_i, len_i);
endmodule

// File: rtl/brtgt_rel_calc.sv
module brtgt_rel_calc #(
  parameter int AW = 16,
  parameter int OW = 8
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] off_i,
  input  logic          taken_i,
  output logic [AW-1:0] target_o
);
  function automatic logic [AW-1:0] f_sext(input logic [OW-1:0] o);
    return {{(AW-OW){o[OW-1]}}, o};
  endfunction

  function automatic logic [AW-1:0] f_rel(input logic [AW-1:0] b, input logic [OW-1:0] o, input logic t);
    return t ? (b + f_sext(o)) : b;
  endfunction

  assign target_o = f_rel(base_i, off_i, taken_i);
endmodule

// File: rtl/brtgt_page_splice.sv
module brtgt_page_splice #(
  parameter int AW = 16,
  parameter int PW = 11
) (
  input  logic [AW-1:0] base_i,
  input  logic [PW-1:0] field_i,
  output logic [AW-1:0] target_o
);
  function automatic logic [AW-1:0] f_splice(input logic [AW-1:0] b, input logic [PW-1:0] f);
    return {b[AW-1:PW], f};
  endfunction

  assign target_o = f_splice(base_i, field_i);
endmodule

// File: rtl/brtgt_gen.sv
module brtgt_gen
  import brtgt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int OW = BYTE_W,
  parameter int PW = PAGE_W,
  parameter int LW = LEN_W,
  parameter logic [AW-1:0] RESET_PC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue_i,
  input  logic [AW-1:0] insn_addr_i,
  input  logic [LW-1:0] insn_len_i,
  input  logic [2:0]    kind_i,
  input  logic [OW-1:0] opnd_lo_i,
  input  logic [OW-1:0] opnd_hi_i,
  input  logic [OW-1:0] acc_i,
  input  logic [AW-1:0] dptr_i,
  input  logic          taken_i,
  output logic [AW-1:0] next_pc_o
);
  localparam int HI_FIELD_W = PW - OW;

  br_kind_e      kind_w;
  logic [AW-1:0] seq_pc_w;
  logic [AW-1:0] rel_pc_w;
  logic [AW-1:0] page_pc_w;
  logic [AW-1:0] long_pc_w;
  logic [AW-1:0] idx_pc_w;
  logic [AW-1:0] nxt_pc_w;
  logic [PW-1:0] page_field_w;

  assign kind_w = br_kind_e'(kind_i);

  brtgt_seq_step #(.AW(AW), .LW(LW)) u_seq (
    .addr_i (insn_addr_i),
    .len_i  (insn_len_i),
    .seq_o  (seq_pc_w)
  );

  brtgt_rel_calc #(.AW(AW), .OW(OW)) u_rel (
    .base_i   (seq_pc_w),
    .off_i    (opnd_lo_i),
    .taken_i  (taken_i),
    .target_o (rel_pc_w)
  );

  assign page_field_w = {opnd_hi_i[HI_FIELD_W-1:0], opnd_lo_i};

  brtgt_page_splice #(.AW(AW), .PW(PW)) u_page (
    .base_i   (seq_pc_w),
    .field_i  (page_field_w),
    .target_o (page_pc_w)
  );

  assign long_pc_w = {opnd_hi_i, opnd_lo_i};
  assign idx_pc_w  = dptr_i + {{(AW-OW){1'b0}}, acc_i};

  always_comb begin
    case (kind_w)
      BK_REL:  nxt_pc_w = rel_pc_w;
      BK_PAGE: nxt_pc_w = page_pc_w;
      BK_LONG: nxt_pc_w = long_pc_w;
      BK_IDX:  nxt_pc_w = idx_pc_w;
      default: nxt_pc_w = seq_pc_w;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       next_pc_o <= RESET_PC;
    else if (issue_i) next_pc_o <= nxt_pc_w;
  end
endmodule

// File: rtl/brtgt_gen_chk.sv
module brtgt_gen_chk #(
  parameter int AW = 16,
  parameter int OW = 8,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          issue_i,
  input logic [2:0]    kind_i,
  input logic          taken_i,
  input logic [AW-1:0] insn_addr_i,
  input logic [LW-1:0] insn_len_i,
  input logic [OW-1:0] opnd_lo_i,
  input logic [OW-1:0] opnd_hi_i,
  input logic [OW-1:0] acc_i,
  input logic [AW-1:0] dptr_i,
  input logic [AW-1:0] seq_pc_w,
  input logic [AW-1:0] next_pc_o
);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> $stable(next_pc_o));

  a_r3_seq_base: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd0) |=> next_pc_o == $past(seq_pc_w));

  a_r5_rel_fallthru: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd1 && !taken_i) |=> next_pc_o == $past(seq_pc_w));

  a_r6_page_top: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd2) |=> next_pc_o[AW-1:11] == $past(seq_pc_w[AW-1:11]));

  a_r6_page_low: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd2) |=> next_pc_o[10:0] == {$past(opnd_hi_i[2:0]), $past(opnd_lo_i)});

  a_r7_long: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd3) |=> next_pc_o == {$past(opnd_hi_i), $past(opnd_lo_i)});

  a_r8_index: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && kind_i == 3'd4) |=> next_pc_o == AW'($past(dptr_i) + AW'($past(acc_i))));

  a_r4_seq_span: assert property (@(posedge clk) disable iff (!rst_n)
    seq_pc_w == AW'(insn_addr_i + AW'(insn_len_i)));
endmodule

bind brtgt_gen brtgt_gen_chk #(.AW(AW), .OW(OW), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .issue_i     (issue_i),
  .kind_i      (kind_i),
  .taken_i     (taken_i),
  .insn_addr_i (insn_addr_i),
  .insn_len_i  (insn_len_i),
  .opnd_lo_i   (opnd_lo_i),
  .opnd_hi_i   (opnd_hi_i),
  .acc_i       (acc_i),
  .dptr_i      (dptr_i),
  .seq_pc_w    (seq_pc_w),
  .next_pc_o   (next_pc_o)
);

// File: tb/sim_brtgt_gen.sv
`timescale 1ns/1ps
module sim_brtgt_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        issue_i = 1'b0;
  logic [15:0] insn_addr_i = '0;
  logic [1:0]  insn_len_i = '0;
  logic [2:0]  kind_i = '0;
  logic [7:0]  opnd_lo_i = '0;
  logic [7:0]  opnd_hi_i = '0;
  logic [7:0]  acc_i = '0;
  logic [15:0] dptr_i = '0;
  logic        taken_i = 1'b0;
  logic [15:0] next_pc_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  brtgt_gen u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .insn_addr_i(insn_addr_i),
    .insn_len_i(insn_len_i), .kind_i(kind_i), .opnd_lo_i(opnd_lo_i),
    .opnd_hi_i(opnd_hi_i), .acc_i(acc_i), .dptr_i(dptr_i), .taken_i(taken_i),
    .next_pc_o(next_pc_o)
  );

  function automatic int model(int k, int a, int n, int lo, int hi, int ac, int dp, bit t);
    int fol;
    int off;
    fol = (a + n) % 65536;
    off = (lo >= 128) ? lo - 256 : lo;
    case (k)
      1: return t ? (fol + off + 65536) % 65536 : fol;
      2: return (fol / 2048) * 2048 + (hi % 8) * 256 + lo;
      3: return hi * 256 + lo;
      4: return (dp + ac) % 65536;
      default: return fol;
    endcase
  endfunction

  task automatic check(string req, logic [15:0] act, int exp);
    checks++;
    if (act !== exp[15:0]) begin
      errors++;
      $display("FAIL %s: got %04h expected %04h", req, act, exp[15:0]);
    end
  endtask

  task automatic fire(int k, int a, int n, int lo, int hi, int ac, int dp, bit t, string req);
    @(negedge clk);
    kind_i = 3'(k); insn_addr_i = 16'(a); insn_len_i = 2'(n);
    opnd_lo_i = 8'(lo); opnd_hi_i = 8'(hi); acc_i = 8'(ac); dptr_i = 16'(dp);
    taken_i = t; issue_i = 1'b1;
    @(negedge clk);
    issue_i = 1'b0;
    check(req, next_pc_o, model(k, a, n, lo, hi, ac, dp, t));
  endtask

  task automatic t_reset;
    check("R1 during reset", next_pc_o, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", next_pc_o, 0);
  endtask

  task automatic t_seq;
    fire(0, 16'h1234, 1, 0, 0, 0, 0, 1'b0, "R3 seq len1");
    fire(0, 16'hFFFE, 3, 0, 0, 0, 0, 1'b1, "R3 seq wrap / R9");
    for (int k = 5; k < 8; k++) fire(k, 16'h0100, 2, 8'h55, 8'hAA, 8'h11, 16'h2222, 1'b1, "R3 spare code");
  endtask

  task automatic t_rel;
    fire(1, 16'h2000, 2, 8'h7F, 0, 0, 0, 1'b1, "R4 max forward");
    fire(1, 16'h2000, 2, 8'h80, 0, 0, 0, 1'b1, "R4 max backward");
    fire(1, 16'hFFFE, 2, 8'h05, 0, 0, 0, 1'b1, "R4 wrap top");
    fire(1, 16'h0001, 2, 8'h80, 0, 0, 0, 1'b1, "R4 wrap bottom");
    fire(1, 16'h3000, 3, 8'hFE, 0, 0, 0, 1'b1, "R4 len3 base");
    fire(1, 16'h2000, 2, 8'h7F, 0, 0, 0, 1'b0, "R5 not taken");
    fire(1, 16'hFFFF, 2, 8'h80, 0, 0, 0, 1'b0, "R5 not taken wrap");
  endtask

  task automatic t_page;
    fire(2, 16'h4A10, 2, 8'h34, 8'h05, 0, 0, 1'b0, "R6 in page");
    fire(2, 16'h07FF, 2, 8'h34, 8'hFF, 0, 0, 1'b0, "R6 page cross ignored hi bits");
    fire(2, 16'hFFFF, 2, 8'hCD, 8'h02, 0, 0, 1'b1, "R6 wrap to page0 / R9");
    fire(2, 16'h07FE, 2, 8'h00, 8'h00, 0, 0, 1'b0, "R6 exact page edge");
  endtask

  task automatic t_long;
    fire(3, 16'h1234, 3, 8'hCD, 8'hAB, 0, 0, 1'b0, "R7 long");
    fire(3, 16'hFFFF, 3, 8'h00, 8'h00, 0, 0, 1'b1, "R7 long zero / R9");
  endtask

  task automatic t_idx;
    fire(4, 16'h1111, 1, 0, 0, 8'h20, 16'h8000, 1'b0, "R8 index");
    fire(4, 16'h1111, 1, 0, 0, 8'hFF, 16'hFFF0, 1'b1, "R8 index wrap / R9");
  endtask

  task automatic t_hold;
    logic [15:0] held;
    fire(3, 0, 3, 8'h78, 8'h56, 0, 0, 1'b0, "R10 load before hold");
    held = next_pc_o;
    @(negedge clk);
    kind_i = 3'd3; opnd_lo_i = 8'h11; opnd_hi_i = 8'h22; taken_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 hold without issue", next_pc_o, int'(held));
  endtask

  initial begin
    t_reset();
    t_seq();
    t_rel();
    t_page();
    t_long();
    t_idx();
    t_hold();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule